// File: doc/BRIEF.md
# Two-Wire Register Target

This block is a target on a two-wire serial bus with open-drain clock and data lines. It gives a small byte-wide register file two kinds of access: bursts of single-byte writes, and sequential reads. Both lines are sampled by the system clock. Each line passes through a synchronizer and a filter that rejects pulses of one system cycle, and only then does edge detection look at it. The block drives the data line only through an active-low enable. The register file sits outside the block and is reached through an address, a write strobe with data, and a read strobe with combinational return data.

A transaction opens with a START. An identification byte follows, and the block answers only to the code 1101111 in its upper seven bits; the lowest bit picks read or write. For a write, the next byte loads the register pointer and each following byte is written, with every byte acknowledged. A read streams bytes out from the pointer. A repeated START after the pointer byte gives a random read. A START is ignored while the power-up input is high.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is held and right after it, the data enable `sda_oe` is 0 and neither `reg_wr` nor `reg_rd` is asserted.
- R2: Bus traffic before any START gets no acknowledge and causes no register access.
- R3: After START, an identification byte whose bits 7..1 are 1101111 is acknowledged (data pulled low during the ninth clock). Any other code is not acknowledged, and the block stays silent until the next START.
- R4: In a write (bit 0 of the identification byte is 0), the byte after the identification byte sets the register pointer to its low `AW` bits and is acknowledged. Each further byte is acknowledged and causes exactly one `reg_wr` pulse carrying that byte and the pointer. `reg_wr` and `reg_rd` are never high together.
- R5: The pointer increments after every byte written or read and wraps from 2**AW-1 to 0.
- R6: In a read (bit 0 is 1), the block sends the register at the pointer MSB first. It pulses `reg_rd` once per byte loaded, and sends the next register after each master acknowledge.
- R7: A master NACK after a read byte makes the block release data and load nothing more until a START.
- R8: STOP (data rising while clock is high) returns the block to idle with data released. Bytes that follow without a START are ignored.
- R9: A repeated START in the middle of a transaction restarts identification decoding.
- R10: A START seen while `pwr_busy` is high is ignored.
- R11: A pulse of one system cycle on either line is filtered out and does not disturb a transfer.
- R12: The block changes its data drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| pwr_busy | input | 1 | Power-up sequence in progress; START is ignored |
| reg_addr | output | AW | Register pointer presented to the register file |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe; `reg_rdata` is captured in the same cycle |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
A pin change reaches the edge detector after the three-stage synchronizer and the filter. Logic then acts on the fifth system clock edge after the pin moves. So `reg_wr` appears about five cycles after the eighth rising clock of a byte, and acknowledge and read bits change about five cycles after a falling clock. The bench keeps each clock phase at least nine system cycles long. It samples the data line in the middle of the clock high phase, well after any drive change. A scoreboard queue matches write strobes in order, whatever cycle they land in. Read strobes are counted between bus phases, not at fixed cycles.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int AW = 4,
  parameter logic [6:0] DEV_ID = 7'b1101111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          pwr_busy,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);

  localparam logic [2:0] S_IDLE = 3'd0, S_ID = 3'd1, S_ADDR = 3'd2, S_WDATA = 3'd3,
                         S_RDATA = 3'd4, S_ACK = 3'd5, S_MACK = 3'd6, S_WAIT = 3'd7;

  logic [2:0] scl_sy, sda_sy;
  logic scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
      scl_f  <= 1'b1;
      sda_f  <= 1'b1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
      if (scl_sy[2] == scl_sy[1]) scl_f <= scl_sy[2];
      if (sda_sy[2] == sda_sy[1]) sda_f <= sda_sy[2];
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_c, stop_c, start_ok;
  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;
  assign start_ok = start_c & ~pwr_busy;

  logic [2:0]    st, nxt, cnt;
  logic [6:0]    sh;
  logic [7:0]    tx, wdata;
  logic          ack_ph, mack, oe, wr_q;
  logic [AW-1:0] addr;
  logic [7:0]    rx_byte;

  assign rx_byte = {sh, sda_f};

  assign sda_oe    = oe;
  assign reg_addr  = addr;
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata;
  assign reg_rd    = scl_fall & ((st == S_ACK && ack_ph && nxt == S_RDATA) ||
                                 (st == S_MACK && mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      nxt    <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      wdata  <= '0;
      ack_ph <= 1'b0;
      mack   <= 1'b0;
      oe     <= 1'b0;
      wr_q   <= 1'b0;
      addr   <= '0;
    end else begin
      wr_q <= 1'b0;
      if (wr_q) addr <= addr + 1'b1;
      if (start_ok) begin
        st     <= S_ID;
        cnt    <= '0;
        oe     <= 1'b0;
        ack_ph <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        oe     <= 1'b0;
        ack_ph <= 1'b0;
      end else begin
        case (st)
          S_ID, S_ADDR, S_WDATA: begin
            if (scl_rise) begin
              sh  <= rx_byte[6:0];
              cnt <= cnt + 1'b1;
              if (cnt == 3'd7) begin
                if (st == S_ID) begin
                  if (rx_byte[7:1] == DEV_ID) begin
                    st  <= S_ACK;
                    nxt <= rx_byte[0] ? S_RDATA : S_ADDR;
                  end else begin
                    st <= S_WAIT;
                  end
                end else if (st == S_ADDR) begin
                  addr <= rx_byte[AW-1:0];
                  st   <= S_ACK;
                  nxt  <= S_WDATA;
                end else begin
                  wr_q  <= 1'b1;
                  wdata <= rx_byte;
                  st    <= S_ACK;
                  nxt   <= S_WDATA;
                end
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (!ack_ph) begin
                ack_ph <= 1'b1;
                oe     <= 1'b1;
              end else begin
                ack_ph <= 1'b0;
                cnt    <= '0;
                st     <= nxt;
                if (nxt == S_RDATA) begin
                  tx <= reg_rdata;
                  oe <= ~reg_rdata[7];
                end else begin
                  oe <= 1'b0;
                end
              end
            end
          end
          S_RDATA: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                oe   <= 1'b0;
                st   <= S_MACK;
                addr <= addr + 1'b1;
              end else begin
                tx  <= {tx[6:0], 1'b0};
                oe  <= ~tx[6];
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack <= ~sda_f;
            if (scl_fall) begin
              if (mack) begin
                tx  <= reg_rdata;
                oe  <= ~reg_rdata[7];
                cnt <= '0;
                st  <= S_RDATA;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic          pwr_busy,
  input logic [2:0]    st,
  input logic          scl_f,
  input logic          start_c,
  input logic          stop_c
);
  localparam logic [2:0] S_IDLE = 3'd0;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !reg_wr && !reg_rd));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == AW'($past(reg_addr) + 1'b1));

  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (st == S_IDLE && !sda_oe));

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pwr_busy && start_c) |=> st == S_IDLE);

  assert_drive_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_f));
endmodule

bind i2c_regslave i2c_regslave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .pwr_busy(pwr_busy), .st(st), .scl_f(scl_f),
  .start_c(start_c), .stop_c(stop_c)
);

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
  localparam int CLK_NS = 10;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, pwr_busy = 1'b0;
  logic sda_oe, reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic scl_i, sda_i;
  logic [7:0] mem [16];

  assign scl_i = m_scl;
  assign sda_i = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  always #(CLK_NS/2) clk = ~clk;
  always_ff @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  i2c_regslave #(.AW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .pwr_busy(pwr_busy), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  int checks = 0, errors = 0, rd_cnt = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  logic [11:0] exp_q [$];
  logic [11:0] mon_e;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        mon_e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == mon_e, "R4 R5 R11 write", {reg_addr, reg_wdata}, mon_e);
      end
    end
    if (reg_rd) rd_cnt++;
    if (sda_oe !== oe_prev && m_scl) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input bit b, input int gl, output bit r);
    m_sda = b; hw(H);
    if (gl == 2) begin m_scl = 1'b1; hw(1); m_scl = 1'b0; hw(2); end
    m_scl = 1'b1; hw(H/2);
    if (gl == 1) begin m_sda = ~b; hw(1); m_sda = b; end
    hw(H/2); r = sda_i; hw(H/2);
    m_scl = 1'b0; hw(H);
  endtask

  task automatic do_start();
    m_sda = 1'b1; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b0; hw(H); m_scl = 1'b0; hw(H);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; hw(H); m_scl = 1'b1; hw(H); m_sda = 1'b1; hw(H);
  endtask

  task automatic send(input logic [7:0] b, input int gbit, input int gk, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bitx(b[i], (i == gbit) ? gk : 0, r);
    bitx(1'b1, 0, r);
    ack = ~r;
  endtask

  task automatic recv(output logic [7:0] b, input bit give_ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin bitx(1'b1, 0, r); b[i] = r; end
    bitx(~give_ack, 0, r);
  endtask

  task automatic wr2(input logic [3:0] a, input logic [7:0] d0, input logic [7:0] d1);
    bit ack;
    logic [3:0] a1;
    a1 = a + 4'd1;
    do_start();
    send(8'hDE, -1, 0, ack); chk(ack, "R3 id ack", ack, 1);
    send({4'h0, a}, -1, 0, ack); chk(ack, "R4 pointer ack", ack, 1);
    exp_q.push_back({a, d0});
    send(d0, -1, 0, ack); chk(ack, "R4 data ack", ack, 1);
    exp_q.push_back({a1, d1});
    send(d1, -1, 0, ack); chk(ack, "R5 second data ack", ack, 1);
    do_stop();
  endtask

  task automatic rd2(input logic [3:0] a, input logic [7:0] e0, input logic [7:0] e1);
    bit ack;
    logic [7:0] b;
    int rc;
    do_start();
    send(8'hDE, -1, 0, ack); chk(ack, "R3 id ack", ack, 1);
    send({4'h0, a}, -1, 0, ack); chk(ack, "R4 pointer ack", ack, 1);
    rc = rd_cnt;
    do_start();
    send(8'hDF, -1, 0, ack); chk(ack, "R9 read id after repeated start", ack, 1);
    recv(b, 1'b1); chk(b == e0, "R6 first read byte", b, e0);
    recv(b, 1'b0); chk(b == e1, "R5 R6 next read byte", b, e1);
    chk(rd_cnt == rc + 2, "R6 read strobes", rd_cnt, rc + 2);
    recv(b, 1'b0); chk(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    chk(rd_cnt == rc + 2, "R7 no load after nack", rd_cnt, rc + 2);
    do_stop();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    bit ack;
    hw(5);
    chk(!sda_oe && !reg_wr && !reg_rd, "R1 reset outputs", {sda_oe, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    hw(10);
    chk(!sda_oe, "R1 released after reset", sda_oe, 0);

    send(8'hDE, -1, 0, ack); chk(!ack, "R2 no start no ack", ack, 0);
    send(8'h01, -1, 0, ack); chk(!ack, "R2 second byte ignored", ack, 0);

    wr2(4'h3, 8'hA5, 8'h5A);
    wr2(4'hF, 8'h11, 8'h22);
    rd2(4'h3, 8'hA5, 8'h5A);
    rd2(4'hF, 8'h11, 8'h22);

    do_start();
    send(8'hBE, -1, 0, ack); chk(!ack, "R3 wrong id no ack", ack, 0);
    send(8'h07, -1, 0, ack); chk(!ack, "R3 silent after wrong id", ack, 0);
    do_start();
    send(8'hDE, -1, 0, ack); chk(ack, "R9 restart after wrong id", ack, 1);
    do_stop();

    do_start();
    send(8'hDE, -1, 0, ack);
    send(8'h05, -1, 0, ack);
    do_stop();
    send(8'h77, -1, 0, ack); chk(!ack, "R8 byte after stop ignored", ack, 0);
    send(8'hDE, -1, 0, ack); chk(!ack, "R8 id after stop ignored", ack, 0);
    do_stop();

    pwr_busy = 1'b1;
    do_start();
    send(8'hDE, -1, 0, ack); chk(!ack, "R10 start ignored while busy", ack, 0);
    do_stop();
    pwr_busy = 1'b0;

    do_start();
    send(8'hDE, -1, 0, ack); chk(ack, "R10 start accepted after busy", ack, 1);
    send(8'h06, -1, 0, ack);
    exp_q.push_back({4'h6, 8'h3C});
    send(8'h3C, 5, 1, ack); chk(ack, "R11 data glitch filtered", ack, 1);
    exp_q.push_back({4'h7, 8'hC3});
    send(8'hC3, 3, 2, ack); chk(ack, "R11 clock glitch filtered", ack, 1);
    do_stop();

    hw(50);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    chk(oe_bad == 0, "R12 drive change with clock high", oe_bad, 0);
    summary();
    $finish;
  end
endmodule